// File: doc/BRIEF.md
# DRAM Maintenance Request Handler

This block sits on the controller side of a DRAM interface. It takes refresh and ZQ short-calibration requests that software or fabric logic raises as one-cycle strobes. It holds each request until every outstanding read or write has completed, and then presents a REF or ZQCS command on a small command port toward the PHY. When the PHY takes that command, the block returns a one-cycle acknowledge to the requester. New data requests are held off while any maintenance command waits, so the drain always finishes. A transaction counter tracks the outstanding work and is visible as a port.

An optional automatic ZQ timer raises internal ZQ requests at a fixed interval of enabled cycles. A configuration pin switches the timer on and off. A zero interval parameter removes the timer altogether, which leaves only user ZQ requests.

The data request input and the PHY command output use valid/ready handshakes. A data request is accepted in a cycle where `data_req_valid` and `data_req_ready` are both high. The block lowers `data_req_ready` while maintenance is waiting or the counter is full. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. Once `cmd_valid` rises, it stays high and `cmd_code` does not change until the PHY accepts the command. Request strobes, acknowledges, the error pulse and the configuration pin are plain signals.

Top module: `maint_req_handler`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ref_ack`, `zq_ack`, `dup_err` and `cmd_valid` are low, `pend_cnt` is 0, `cmd_code` is 2'b00 and `data_req_ready` is high.
- R2: A `ref_req` strobe marks a refresh as pending. When the PHY takes a command with code 2'b01 (REF), `ref_ack` goes high for exactly one cycle, on the cycle after that handshake.
- R3: A `zq_req` strobe marks a user ZQ as pending. When the PHY takes a command with code 2'b10 (ZQCS) while a user ZQ is pending, `zq_ack` goes high for exactly one cycle, on the cycle after that handshake.
- R4: `cmd_valid` is high only while some maintenance request is pending and `pend_cnt` is 0. `data_req_ready` is low while any maintenance request is pending.
- R5: If refresh and ZQ are both pending when the drain completes, REF is presented first and ZQCS follows on the next command slot.
- R6: A strobe of a request type that is still pending is ignored, so that only one command of that type is issued. `dup_err` is high for exactly the cycle after such a strobe.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_code` keeps its value on the next cycle. `cmd_code` is 2'b00 whenever `cmd_valid` is low.
- R8: With `ZQ_INTERVAL` > 0 and `cfg_auto_zq` high, an internal ZQ request is raised on every `ZQ_INTERVAL`-th consecutive enabled cycle. The timer restarts from zero while `cfg_auto_zq` is low. An automatic ZQCS produces no `zq_ack`. With `cfg_auto_zq` low, or `ZQ_INTERVAL` = 0, no automatic ZQ is raised.
- R9: `pend_cnt` rises by one for each accepted data request and falls by one for each `txn_done` pulse. `data_req_ready` is low when `pend_cnt` equals `MAX_PEND`.
- R10: A user ZQ and an automatic ZQ that are pending together are served by a single ZQCS command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | input | 1 | One-cycle refresh request strobe |
| zq_req | input | 1 | One-cycle ZQ calibration request strobe |
| cfg_auto_zq | input | 1 | Enables the automatic ZQ interval timer |
| data_req_valid | input | 1 | New data transaction offered |
| data_req_ready | output | 1 | New data transaction may be accepted |
| txn_done | input | 1 | One outstanding data transaction has finished |
| pend_cnt | output | $clog2(MAX_PEND+1) | Outstanding data transaction count |
| cmd_valid | output | 1 | Maintenance command presented to the PHY |
| cmd_ready | input | 1 | PHY accepts the presented command |
| cmd_code | output | 2 | 2'b01 REF, 2'b10 ZQCS, 2'b00 idle |
| ref_ack | output | 1 | One-cycle refresh acknowledge |
| zq_ack | output | 1 | One-cycle user ZQ acknowledge |
| dup_err | output | 1 | One-cycle duplicate-request flag |

## Verification
The bench builds the block with `MAX_PEND` = 4 and `ZQ_INTERVAL` = 40. The small counter limit means random traffic reaches the full-counter stall often, not just in one directed case. The short interval fits several automatic ZQ periods into a few hundred cycles. This lets the bench check automatic ZQ requests against refresh, user ZQ, duplicate strobes and PHY back-pressure. Toggling `cfg_auto_zq` during the run also covers the disabled timer and its restart.

// File: rtl/maint_pkg.sv
package maint_pkg;
  typedef enum logic [1:0] {
    MC_IDLE = 2'b00,
    MC_REF  = 2'b01,
    MC_ZQCS = 2'b10
  } mcmd_e;

  localparam int unsigned NUM_USER_REQ = 2;
  localparam int unsigned IDX_REF = 0;
  localparam int unsigned IDX_ZQ  = 1;
endpackage

// File: rtl/mr_req_slot.sv
module mr_req_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic clear,
  output logic pend,
  output logic dup
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (pend) pend <= !clear;
    else pend <= strobe;
  end

  assign dup = strobe & pend;

  // a duplicate strobe must not re-arm a request that is being cleared
  p_dup_no_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && clear) |=> !pend);
endmodule

// File: rtl/mr_txn_count.sv
module mr_txn_count #(
  parameter int unsigned MAX_PEND = 16,
  localparam int unsigned CW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          done,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (accept && !done) cnt <= cnt + 1'b1;
    else if (done && !accept) cnt <= cnt - 1'b1;
  end

  p_cnt_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_PEND));
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !done) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/mr_auto_zq.sv
module mr_auto_zq #(
  parameter int unsigned ZQ_INTERVAL = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (ZQ_INTERVAL == 0) begin : g_off
      assign tick = 1'b0;
    end else begin : g_on
      localparam int unsigned TW = (ZQ_INTERVAL > 1) ? $clog2(ZQ_INTERVAL) : 1;
      localparam logic [TW-1:0] LAST = TW'(ZQ_INTERVAL - 1);
      logic [TW-1:0] tmr;
      always_ff @(posedge clk) begin
        if (!rst_n || !en) tmr <= '0;
        else if (tmr == LAST) tmr <= '0;
        else tmr <= tmr + 1'b1;
      end
      assign tick = en && (tmr == LAST);

      p_no_tick_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tmr == '0));
    end
  endgenerate
endmodule

// File: rtl/maint_req_handler.sv
module maint_req_handler #(
  parameter int unsigned MAX_PEND    = 16,
  parameter int unsigned ZQ_INTERVAL = 1024,
  localparam int unsigned CW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_req,
  input  logic          zq_req,
  input  logic          cfg_auto_zq,
  input  logic          data_req_valid,
  output logic          data_req_ready,
  input  logic          txn_done,
  output logic [CW-1:0] pend_cnt,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_code,
  output logic          ref_ack,
  output logic          zq_ack,
  output logic          dup_err
);
  import maint_pkg::*;

  logic [NUM_USER_REQ-1:0] strobe, clear, pend, dup;
  logic auto_tick, auto_pend, any_pend, drained, hs, accept;
  logic lock_q;
  mcmd_e lcode_q, sel_code, code;

  assign strobe[IDX_REF] = ref_req;
  assign strobe[IDX_ZQ]  = zq_req;

  for (genvar i = 0; i < NUM_USER_REQ; i++) begin : g_slot
    mr_req_slot u_slot (
      .clk(clk), .rst_n(rst_n), .strobe(strobe[i]),
      .clear(clear[i]), .pend(pend[i]), .dup(dup[i])
    );
  end

  mr_txn_count #(.MAX_PEND(MAX_PEND)) u_cnt (
    .clk(clk), .rst_n(rst_n), .accept(accept), .done(txn_done), .cnt(pend_cnt)
  );

  mr_auto_zq #(.ZQ_INTERVAL(ZQ_INTERVAL)) u_auto (
    .clk(clk), .rst_n(rst_n), .en(cfg_auto_zq), .tick(auto_tick)
  );

  assign any_pend = |pend | auto_pend;
  assign drained  = (pend_cnt == '0);
  assign cmd_valid = any_pend && drained;
  assign sel_code = lock_q ? lcode_q : (pend[IDX_REF] ? MC_REF : MC_ZQCS);
  assign code     = cmd_valid ? sel_code : MC_IDLE;
  assign cmd_code = code;
  assign hs       = cmd_valid && cmd_ready;

  assign clear[IDX_REF] = hs && (code == MC_REF);
  assign clear[IDX_ZQ]  = hs && (code == MC_ZQCS);

  assign data_req_ready = !any_pend && (pend_cnt != CW'(MAX_PEND));
  assign accept = data_req_valid && data_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      lcode_q   <= MC_IDLE;
      auto_pend <= 1'b0;
      ref_ack   <= 1'b0;
      zq_ack    <= 1'b0;
      dup_err   <= 1'b0;
    end else begin
      if (hs) lock_q <= 1'b0;
      else if (cmd_valid) begin
        lock_q  <= 1'b1;
        lcode_q <= sel_code;
      end
      auto_pend <= (auto_pend && !clear[IDX_ZQ]) || auto_tick;
      ref_ack   <= clear[IDX_REF];
      zq_ack    <= clear[IDX_ZQ] && pend[IDX_ZQ];
      dup_err   <= |dup;
    end
  end

  p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (pend_cnt == '0));
  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> !data_req_ready);
  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code)));
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |=> !ref_ack);
  p_ack_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_ack) |-> $past(hs && cmd_code == 2'b01));
  p_zq_ack_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zq_ack |-> $past(hs && cmd_code == 2'b10));
  p_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> $past(ref_req || zq_req));
  p_ref_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !lock_q && pend[IDX_REF]) |-> cmd_code == 2'b01);
endmodule

// File: tb/test_maint_req_handler.sv
module test_maint_req_handler;
  localparam int MAXP = 4;
  localparam int ZQI  = 40;
  localparam int CW   = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_req = 0, zq_req = 0, cfg_auto_zq = 0, data_req_valid = 0;
  logic txn_done = 0, cmd_ready = 0;
  logic data_req_ready, cmd_valid, ref_ack, zq_ack, dup_err;
  logic [CW-1:0] pend_cnt;
  logic [1:0] cmd_code;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  maint_req_handler #(.MAX_PEND(MAXP), .ZQ_INTERVAL(ZQI)) i_maint_req_handler (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .zq_req(zq_req),
    .cfg_auto_zq(cfg_auto_zq), .data_req_valid(data_req_valid),
    .data_req_ready(data_req_ready), .txn_done(txn_done), .pend_cnt(pend_cnt),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .ref_ack(ref_ack), .zq_ack(zq_ack), .dup_err(dup_err)
  );

  // reference model
  logic m_ref, m_zq, m_auto, m_lock, m_rack, m_zack, m_err;
  logic [1:0] m_lcode;
  int m_cnt, m_tmr;

  function automatic logic e_any();
    return m_ref | m_zq | m_auto;
  endfunction
  function automatic logic e_valid();
    return e_any() && (m_cnt == 0);
  endfunction
  function automatic logic [1:0] e_code();
    if (!e_valid()) return 2'b00;
    if (m_lock) return m_lcode;
    return m_ref ? 2'b01 : 2'b10;
  endfunction
  function automatic logic e_ready();
    return !e_any() && (m_cnt < MAXP);
  endfunction

  always @(posedge clk) begin : model
    logic hs, cr, cz, tick;
    if (!rst_n) begin
      m_ref <= 0; m_zq <= 0; m_auto <= 0; m_lock <= 0; m_lcode <= 0;
      m_rack <= 0; m_zack <= 0; m_err <= 0; m_cnt <= 0; m_tmr <= 0;
    end else begin
      hs = e_valid() && cmd_ready;
      cr = hs && e_code() == 2'b01;
      cz = hs && e_code() == 2'b10;
      tick = cfg_auto_zq && (m_tmr == ZQI - 1);
      m_tmr <= (cfg_auto_zq && !tick) ? m_tmr + 1 : 0;
      m_ref <= m_ref ? !cr : ref_req;
      m_zq  <= m_zq ? !cz : zq_req;
      m_auto <= (m_auto && !cz) || tick;
      if (hs) m_lock <= 0;
      else if (e_valid()) begin m_lock <= 1; m_lcode <= e_code(); end
      m_rack <= cr;
      m_zack <= cz && m_zq;
      m_err  <= (ref_req && m_ref) || (zq_req && m_zq);
      m_cnt  <= m_cnt + ((data_req_valid && e_ready()) ? 1 : 0) - (txn_done ? 1 : 0);
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 ref_ack", ref_ack, m_rack);
    chk("R3 zq_ack", zq_ack, m_zack);
    chk("R6 dup_err", dup_err, m_err);
    chk("R4 cmd_valid", cmd_valid, e_valid());
    chk("R7 cmd_code", cmd_code, e_code());
    chk("R9 ready", data_req_ready, e_ready());
    chk("R9 pend_cnt", pend_cnt, m_cnt);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    ref_req = 0; zq_req = 0; data_req_valid = 0; txn_done = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int zq_cmds, acks;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 cmd_valid in reset", cmd_valid, 0);
    chk("R1 pend_cnt in reset", pend_cnt, 0);
    chk("R1 ready in reset", data_req_ready, 1);
    rst_n = 1;
    cyc();
    chk("R1 ref_ack", ref_ack, 0);
    chk("R1 zq_ack", zq_ack, 0);
    chk("R1 dup_err", dup_err, 0);
    chk("R1 cmd_code", cmd_code, 0);

    // R5 both pending at once, REF first
    cmd_ready = 0; ref_req = 1; zq_req = 1;
    cyc(); idle_inputs();
    chk("R5 first valid", cmd_valid, 1);
    chk("R5 first REF", cmd_code, 1);
    chk("R4 stall while pending", data_req_ready, 0);
    cmd_ready = 1;
    cyc();
    chk("R2 ref_ack after REF", ref_ack, 1);
    chk("R5 then ZQCS", cmd_code, 2);
    cyc();
    chk("R3 zq_ack after ZQCS", zq_ack, 1);
    chk("R2 ref_ack single", ref_ack, 0);
    cyc();
    chk("R5 idle after both", cmd_valid, 0);

    // R6 duplicate strobe
    cmd_ready = 0; ref_req = 1;
    cyc();
    cyc(); idle_inputs();
    chk("R6 dup flag", dup_err, 1);
    cmd_ready = 1;
    cyc();
    chk("R6 one REF ack", ref_ack, 1);
    chk("R6 dup pulse ends", dup_err, 0);
    cyc();
    chk("R6 no second REF", cmd_valid, 0);

    // R4 drain
    data_req_valid = 1;
    cyc(); cyc();
    data_req_valid = 0; ref_req = 1;
    cyc(); ref_req = 0;
    chk("R4 held while draining", cmd_valid, 0);
    chk("R9 count two", pend_cnt, 2);
    txn_done = 1;
    cyc();
    chk("R4 still draining", cmd_valid, 0);
    cyc(); txn_done = 0;
    chk("R4 issue after drain", cmd_valid, 1);
    cyc(); cyc();

    // R9 counter cap
    data_req_valid = 1;
    repeat (6) cyc();
    chk("R9 capped", pend_cnt, MAXP);
    chk("R9 ready low at cap", data_req_ready, 0);
    data_req_valid = 0; txn_done = 1;
    repeat (MAXP) cyc();
    txn_done = 0;
    chk("R9 drained", pend_cnt, 0);

    // R8 automatic ZQ
    cfg_auto_zq = 1; cmd_ready = 1; zq_cmds = 0; acks = 0;
    for (int i = 0; i < 210; i++) begin
      cyc();
      if (cmd_valid && cmd_ready && cmd_code == 2'b10) zq_cmds++;
      if (zq_ack) acks++;
    end
    chk("R8 auto ZQ count", zq_cmds, 5);
    chk("R8 no user ack", acks, 0);
    cfg_auto_zq = 0; zq_cmds = 0;
    for (int i = 0; i < 100; i++) begin
      cyc();
      if (cmd_valid) zq_cmds++;
    end
    chk("R8 none when disabled", zq_cmds, 0);

    // R10 merge user and auto ZQ
    cfg_auto_zq = 1; cmd_ready = 0;
    for (int i = 0; i < 60 && !cmd_valid; i++) cyc();
    cfg_auto_zq = 0; zq_req = 1;
    cyc(); zq_req = 0; cmd_ready = 1;
    cyc();
    chk("R10 zq_ack once", zq_ack, 1);
    cyc();
    chk("R10 single ZQCS", cmd_valid, 0);

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      ref_req = ($urandom_range(0, 19) == 0);
      zq_req  = ($urandom_range(0, 19) == 0);
      data_req_valid = $urandom_range(0, 1);
      txn_done = (m_cnt > 0) && ($urandom_range(0, 9) < 4);
      cmd_ready = ($urandom_range(0, 9) < 6);
      if (i % 500 == 0) cfg_auto_zq = $urandom_range(0, 1);
      cyc();
    end
    idle_inputs();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule